// File: doc/BRIEF.md
# Register Hazard Tracker with Execute Bypass

This block sits beside the issue stage of an in-order pipeline. It remembers which register writes are still in flight. For each source operand of the instruction being offered for issue, it returns one of three results: no conflict, stall, or take the operand from the execute unit's output instead of the register file. Indices address a 64-entry space that holds the general registers and the most used special registers, such as the link and count registers. The condition register is tracked on its own, as a single resource.

A write is recorded only when the issue stage hands its instruction downstream, which means issue is valid and busy is low. Each record holds the destination index, a flag telling whether the result can be forwarded, and an optional second write of a base register, as done by update-form loads and stores. Records move through a chain of tracking slots: one slot for the execute stage and one more after it. A record drops out when it leaves the last slot, which is the point where its write reaches the register file.

Forwarding is offered only when the newest slot holds the writer and that writer is flagged as forwardable. A match against any older writer, or against a base-register write, gives a stall. The operand multiplexers are outside this block. The issue stage is expected to drop its valid while any stall output is high.

Top module: `hazard_tracker`

## Requirements
- R1: After reset every slot is empty, so no stall, bypass or condition-register stall output is raised for any source.
- R2: A valid source whose index matches a non-forwardable destination write held in the newest slot raises that operand's stall and not its bypass.
- R3: A valid source whose index matches a forwardable destination write in the newest slot raises that operand's bypass and not its stall, provided no base-register write in that slot also matches.
- R4: A source that matches a write held in any slot other than the newest raises a stall, even when that write was flagged forwardable.
- R5: With busy low, a recorded write raises hazards for exactly STAGES cycles after its issue (default 2). After that it raises none.
- R6: The base-register write of an update-form access is tracked like a destination write. A match against it always stalls and never forwards.
- R7: The condition register is one resource. A condition-register read stalls while any slot holds a condition-register writer, and does not stall otherwise.
- R8: A source whose index is 0, or whose valid flag is low, never raises stall or bypass.
- R9: Writes are recorded only in a cycle where issue valid is high and busy is low. Write-enable inputs in any other cycle have no effect.
- R10: While busy is high, the newest slot keeps its record. Older slots advance, and an empty record enters behind the newest slot.
- R11: The three operands are checked independently. Operand k takes its index from src_idx_i bits [6k+5:6k] and reports on bit k of src_stall_o and src_byp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Issue stage offers an instruction |
| busy_i | input | 1 | Downstream did not take the offered instruction |
| dst_we_i | input | 1 | Instruction writes a destination register |
| dst_idx_i | input | 6 | Destination register index |
| dst_byp_i | input | 1 | Destination result comes from the single-cycle execute unit |
| base_we_i | input | 1 | Update-form access writes its base register |
| base_idx_i | input | 6 | Base register index |
| cr_we_i | input | 1 | Instruction writes the condition register |
| src_valid_i | input | 3 | Per-operand source in use |
| src_idx_i | input | 18 | Packed source indices, operand k at [6k+5:6k] |
| cr_read_i | input | 1 | Instruction reads the condition register |
| src_stall_o | output | 3 | Per-operand stall |
| src_byp_o | output | 3 | Per-operand use-bypass |
| cr_stall_o | output | 1 | Condition-register stall |

## Verification
The assertions check four things on every cycle. A zero index or an unused operand stays silent. Busy freezes the newest slot. A cycle without an accepted issue leaves the newest slot empty. In the cycle after an accepted issue, a forwardable write gives a bypass, a base-register write gives a stall, and a condition-register write stalls a reader. The bench scenarios show the rest: writes aging from bypass to stall and then to retirement, the bubble that busy inserts, write enables ignored while busy, and independent results across the three operands.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int HZ_IDX_W = 6;

    // One tracked instruction in a slot
    typedef struct packed {
        logic                dst_v;
        logic [HZ_IDX_W-1:0] dst_idx;
        logic                dst_byp;
        logic                base_v;
        logic [HZ_IDX_W-1:0] base_idx;
        logic                cr_v;
    } hz_slot_t;

    localparam hz_slot_t HZ_EMPTY = '0;

endpackage

// File: rtl/hz_slot_pipe.sv
module hz_slot_pipe
    import hz_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid_i,
    input  logic                    busy_i,
    input  hz_slot_t                new_i,
    output hz_slot_t [STAGES-1:0]   slots_o
);

    typedef struct packed {
        hz_slot_t [STAGES-1:0] slot;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // newest slot: loads on hand-off, empties when idle, holds on busy
        if (!busy_i) begin
            st_d.slot[0] = issue_valid_i ? new_i : HZ_EMPTY;
        end
        for (int i = 1; i < STAGES; i++) begin
            if (i == 1 && busy_i) begin
                st_d.slot[i] = HZ_EMPTY;
            end else begin
                st_d.slot[i]         = st_q.slot[i-1];
                st_d.slot[i].dst_byp = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots_o = st_q.slot;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(slots_o[0])) else $error("busy hold");  // R10

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid_i && !busy_i) |=> (slots_o[0] == HZ_EMPTY)) else $error("idle entry");  // R9

endmodule

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_v_i,
    input  logic [HZ_IDX_W-1:0]    src_idx_i,
    input  hz_slot_t [STAGES-1:0]  slots_i,
    output logic                   stall_o,
    output logic                   byp_o
);

    logic live;
    logic any_hit;
    logic young_fwd;
    logic young_base;

    always_comb begin
        live       = src_v_i && (src_idx_i != '0);
        any_hit    = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (live && slots_i[i].dst_v && slots_i[i].dst_idx == src_idx_i) any_hit = 1'b1;
            if (live && slots_i[i].base_v && slots_i[i].base_idx == src_idx_i) any_hit = 1'b1;
        end
        young_fwd  = live && slots_i[0].dst_v && slots_i[0].dst_byp
                     && (slots_i[0].dst_idx == src_idx_i);
        young_base = live && slots_i[0].base_v && (slots_i[0].base_idx == src_idx_i);
        byp_o      = young_fwd && !young_base;
        stall_o    = any_hit && !byp_o;
    end

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_v_i || src_idx_i == '0) |-> (!stall_o && !byp_o)) else $error("quiet src");  // R8

endmodule

// File: rtl/hazard_tracker.sv
module hazard_tracker
    import hz_pkg::*;
#(
    parameter int NSRC   = 3,
    parameter int STAGES = 2,
    localparam int IW    = HZ_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid_i,
    input  logic               busy_i,
    input  logic               dst_we_i,
    input  logic [IW-1:0]      dst_idx_i,
    input  logic               dst_byp_i,
    input  logic               base_we_i,
    input  logic [IW-1:0]      base_idx_i,
    input  logic               cr_we_i,
    input  logic [NSRC-1:0]    src_valid_i,
    input  logic [NSRC*IW-1:0] src_idx_i,
    input  logic               cr_read_i,
    output logic [NSRC-1:0]    src_stall_o,
    output logic [NSRC-1:0]    src_byp_o,
    output logic               cr_stall_o
);

    hz_slot_t              new_rec;
    hz_slot_t [STAGES-1:0] slots;
    logic                  cr_busy;

    always_comb begin
        new_rec          = HZ_EMPTY;
        new_rec.dst_v    = dst_we_i;
        new_rec.dst_idx  = dst_idx_i;
        new_rec.dst_byp  = dst_we_i && dst_byp_i;
        new_rec.base_v   = base_we_i;
        new_rec.base_idx = base_idx_i;
        new_rec.cr_v     = cr_we_i;
    end

    hz_slot_pipe #(.STAGES(STAGES)) pipe_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid_i (issue_valid_i),
        .busy_i        (busy_i),
        .new_i         (new_rec),
        .slots_o       (slots)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        hz_src_match #(.STAGES(STAGES)) match_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_v_i   (src_valid_i[k]),
            .src_idx_i (src_idx_i[k*IW +: IW]),
            .slots_i   (slots),
            .stall_o   (src_stall_o[k]),
            .byp_o     (src_byp_o[k])
        );
    end

    always_comb begin
        cr_busy = 1'b0;
        for (int i = 0; i < STAGES; i++) cr_busy = cr_busy | slots[i].cr_v;
        cr_stall_o = cr_read_i && cr_busy;
    end

    AST_CR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_valid_i && !busy_i && cr_we_i) && cr_read_i)
        |-> cr_stall_o) else $error("cr pending");  // R7

    AST_BASE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_valid_i && !busy_i && base_we_i) && $past(base_idx_i) != '0
         && src_valid_i[0] && src_idx_i[IW-1:0] == $past(base_idx_i))
        |-> (src_stall_o[0] && !src_byp_o[0])) else $error("base write");  // R6

    AST_YOUNG_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_valid_i && !busy_i && dst_we_i && dst_byp_i && !base_we_i)
         && $past(dst_idx_i) != '0 && src_valid_i[0] && src_idx_i[IW-1:0] == $past(dst_idx_i))
        |-> (src_byp_o[0] && !src_stall_o[0])) else $error("young forward");  // R3

endmodule

// File: tb/hazard_tracker_tb_top.sv
module hazard_tracker_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid_i, busy_i, dst_we_i, dst_byp_i, base_we_i, cr_we_i, cr_read_i;
    logic [5:0]  dst_idx_i, base_idx_i;
    logic [2:0]  src_valid_i;
    logic [17:0] src_idx_i;
    logic [2:0]  src_stall_o, src_byp_o;
    logic        cr_stall_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i), .busy_i(busy_i),
        .dst_we_i(dst_we_i), .dst_idx_i(dst_idx_i), .dst_byp_i(dst_byp_i),
        .base_we_i(base_we_i), .base_idx_i(base_idx_i), .cr_we_i(cr_we_i),
        .src_valid_i(src_valid_i), .src_idx_i(src_idx_i), .cr_read_i(cr_read_i),
        .src_stall_o(src_stall_o), .src_byp_o(src_byp_o), .cr_stall_o(cr_stall_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        issue_valid_i = 0; busy_i = 0; dst_we_i = 0; dst_byp_i = 0; base_we_i = 0;
        cr_we_i = 0; cr_read_i = 0; dst_idx_i = 0; base_idx_i = 0;
        src_valid_i = 0; src_idx_i = 0;
    endtask

    // offer one instruction for one clock, then idle inputs
    task automatic issue_op(input logic [5:0] d, input logic byp, input logic bw,
                            input logic [5:0] b, input logic cw);
        clear_in();
        issue_valid_i = 1; dst_we_i = (d != 0) || byp; dst_idx_i = d; dst_byp_i = byp;
        base_we_i = bw; base_idx_i = b; cr_we_i = cw;
        @(negedge clk);
        clear_in();
    endtask

    task automatic probe(input logic [2:0] v, input logic [5:0] a, input logic [5:0] b,
                         input logic [5:0] c);
        src_valid_i = v; src_idx_i = {c, b, a};
        #1;
    endtask

    task automatic idle_cycle();
        clear_in();
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_in();
        rst_n = 0;
        issue_valid_i = 1; dst_we_i = 1; dst_idx_i = 5; cr_we_i = 1;
        repeat (3) @(negedge clk);
        clear_in();
        rst_n = 1;
        probe(3'b111, 6'd5, 6'd1, 6'd63);
        cr_read_i = 1; #1;
        chk("R1 stall", {1'b0, src_stall_o}, 4'h0);
        chk("R1 byp", {1'b0, src_byp_o}, 4'h0);
        chk("R1 cr", {3'b0, cr_stall_o}, 4'h0);
        idle_cycle();
    endtask

    task automatic t_nonfwd();
        issue_op(6'd12, 1'b0, 1'b0, 6'd0, 1'b0);
        probe(3'b001, 6'd12, 6'd0, 6'd0);
        chk("R2 stall", {3'b0, src_stall_o[0]}, 4'h1);
        chk("R2 byp", {3'b0, src_byp_o[0]}, 4'h0);
        idle_cycle(); idle_cycle();
    endtask

    task automatic t_age_retire();
        issue_op(6'd40, 1'b1, 1'b0, 6'd0, 1'b0);
        probe(3'b001, 6'd40, 6'd0, 6'd0);
        chk("R3 byp", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h2);
        idle_cycle();
        probe(3'b001, 6'd40, 6'd0, 6'd0);
        chk("R4 old slot stalls", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h1);
        idle_cycle();
        probe(3'b001, 6'd40, 6'd0, 6'd0);
        chk("R5 retired", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h0);
        idle_cycle();
    endtask

    task automatic t_base();
        issue_op(6'd3, 1'b1, 1'b1, 6'd4, 1'b0);
        probe(3'b011, 6'd4, 6'd3, 6'd0);
        chk("R6 base stalls", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h1);
        chk("R6 dst still fwd", {2'b0, src_byp_o[1], src_stall_o[1]}, 4'h2);
        idle_cycle();
        probe(3'b001, 6'd4, 6'd0, 6'd0);
        chk("R6 base older", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h1);
        idle_cycle();
    endtask

    task automatic t_cr();
        issue_op(6'd0, 1'b0, 1'b0, 6'd0, 1'b1);
        cr_read_i = 0; #1;
        chk("R7 no read", {3'b0, cr_stall_o}, 4'h0);
        cr_read_i = 1; #1;
        chk("R7 newest", {3'b0, cr_stall_o}, 4'h1);
        idle_cycle();
        cr_read_i = 1; #1;
        chk("R7 older", {3'b0, cr_stall_o}, 4'h1);
        idle_cycle();
        cr_read_i = 1; #1;
        chk("R7 retired", {3'b0, cr_stall_o}, 4'h0);
        idle_cycle();
    endtask

    task automatic t_zero();
        issue_op(6'd0, 1'b1, 1'b1, 6'd0, 1'b0);
        probe(3'b001, 6'd0, 6'd0, 6'd0);
        chk("R8 index zero", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h0);
        idle_cycle();
        issue_op(6'd22, 1'b0, 1'b0, 6'd0, 1'b0);
        probe(3'b000, 6'd22, 6'd22, 6'd22);
        chk("R8 unused", {1'b0, src_stall_o | src_byp_o}, 4'h0);
        idle_cycle(); idle_cycle();
    endtask

    task automatic t_gate_busy();
        clear_in();
        dst_we_i = 1; dst_idx_i = 17; cr_we_i = 1;
        @(negedge clk);
        clear_in();
        probe(3'b001, 6'd17, 6'd0, 6'd0);
        cr_read_i = 1; #1;
        chk("R9 no valid", {1'b0, src_stall_o[0], src_byp_o[0], cr_stall_o}, 4'h0);
        idle_cycle();
        issue_op(6'd30, 1'b1, 1'b0, 6'd0, 1'b0);
        // hold busy with a new offer that must not be recorded
        busy_i = 1; issue_valid_i = 1; dst_we_i = 1; dst_idx_i = 9; cr_we_i = 1;
        repeat (3) @(negedge clk);
        src_valid_i = 3'b011; src_idx_i = {6'd0, 6'd9, 6'd30}; cr_read_i = 1; #1;
        chk("R10 held fwd", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h2);
        chk("R9 busy no entry", {2'b0, src_stall_o[1], cr_stall_o}, 4'h0);
        clear_in();
        @(negedge clk);
        probe(3'b001, 6'd30, 6'd0, 6'd0);
        chk("R10 advanced", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h1);
        idle_cycle();
        probe(3'b001, 6'd30, 6'd0, 6'd0);
        chk("R10 gone", {2'b0, src_byp_o[0], src_stall_o[0]}, 4'h0);
        idle_cycle();
    endtask

    task automatic t_operands();
        issue_op(6'd7, 1'b0, 1'b0, 6'd0, 1'b0);
        probe(3'b111, 6'd7, 6'd8, 6'd7);
        chk("R11 stall mask", {1'b0, src_stall_o}, 4'h5);
        chk("R11 byp mask", {1'b0, src_byp_o}, 4'h0);
        idle_cycle(); idle_cycle();
        issue_op(6'd50, 1'b1, 1'b0, 6'd0, 1'b0);
        probe(3'b110, 6'd50, 6'd1, 6'd50);
        chk("R11 byp only op2", {1'b0, src_byp_o}, 4'h4);
        chk("R11 no stall", {1'b0, src_stall_o}, 4'h0);
        idle_cycle(); idle_cycle();
    endtask

    initial begin
        clear_in();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_nonfwd();
        t_age_retire();
        t_base();
        t_cr();
        t_zero();
        t_gate_busy();
        t_operands();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule